// File: doc/BRIEF.md
# Serial Register Target with Descending Stream Access

This block is the device side of a four-wire serial port: an active-low select, a serial clock, a data input and a push-pull data output. It turns serial frames from a host into accesses on a simple byte-wide register port. A register file or a set of status registers sits behind that port. The serial clock is not used as a clock. It is oversampled by the system clock, so everything runs in one clock domain.

Every frame opens with a 16-bit instruction, sent most significant bit first. Bit 15 picks the direction (1 reads, 0 writes) and bits 14:0 give the starting register address. Data bytes follow for as long as select stays low. After each byte the address steps down by one, and it wraps from 0x0000 to 0x7FFF. A host can therefore fetch a multi-byte value, most significant byte first, in one frame. Writes reach the register port only as complete bytes. Reads are fetched one byte ahead, so the data is ready before the host needs its first bit.

Top module: `serial_reg_target`

## Requirements
- R1: The first 16 bits of a frame are the instruction, most significant bit first. Bit 15 set means read and bit 15 clear means write. Bits 14:0 are the first register address.
- R2: Data input bits are taken on the rising serial clock edge, most significant bit first. A write byte produces exactly one single-cycle `rf_wr_o` pulse, with the byte's address and data, after its eighth bit has been received.
- R3: Read data leaves on `sdo_o` most significant bit first, and it changes only after a falling serial clock edge. Bit 7 of the first byte is valid at the 17th rising edge of the frame.
- R4: While select stays low, each further group of 8 clocks accesses the address one below the previous one, for reads and for writes alike.
- R5: Stepping down from address 0x0000 gives address 0x7FFF.
- R6: Raising select aborts the frame at any point. A write byte that is only partly received is never committed, and the next frame starts again with an instruction.
- R7: `sdo_o` is 0 during all 16 instruction bits, throughout write frames and whenever select is high.
- R8: A read of an address for which the register port reports `rf_hit_i` = 0 shifts out 0x00, whatever `rf_rdata_i` holds.
- R9: While reset is held and right after it, `sdo_o`, `rf_wr_o` and `rf_rd_o` are 0.
- R10: A frame of 48 serial clocks starting with a read of 0x0203 returns, in order, the bytes at 0x0203, 0x0202, 0x0201 and 0x0200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host, push-pull |
| rf_addr_o | output | 15 | Register port address |
| rf_wr_o | output | 1 | Register write strobe, one cycle |
| rf_wdata_o | output | 8 | Register write data |
| rf_rd_o | output | 1 | Register read strobe, one cycle |
| rf_rdata_i | input | 8 | Register read data, valid in the strobe cycle |
| rf_hit_i | input | 1 | Address is mapped, valid in the strobe cycle |

## Verification
The bench streams writes and reads across several bytes, including a stream that crosses address 0x0000. A design with the wrong step direction, or with a 16-bit wrap, would return or store bytes at the wrong addresses. It aborts one frame partway through a write data byte and another partway through an instruction. A design that committed partial bytes would raise an unexpected write strobe, and one that kept its bit count would misread the next instruction. It reads an unmapped address while the register port drives nonzero data, which catches a design that forwards `rf_rdata_i` unfiltered. It also checks `sdo_o` on every instruction bit, which exposes output data that starts early or is shifted by one bit.

// File: rtl/spi_tgt_pkg.sv
// Package: shared widths and types for the serial register target.
// Assumes an 8-bit data byte and a 16-bit instruction whose top bit is the direction.
package spi_tgt_pkg;
    localparam int INSTR_W = 16;
    localparam int ADDR_W  = INSTR_W - 1;
    localparam int DATA_W  = 8;
    localparam int ICNT_W  = $clog2(INSTR_W);

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;
endpackage

// File: rtl/pin_sampler.sv
// Module: pin_sampler
// Brings the three asynchronous serial inputs into the system clock domain and
// detects serial clock edges. Assumes the serial clock is held high and low for
// at least a few system clocks each. All three inputs go through equal-depth
// pipes, so a data bit is seen in the same cycle as its rising edge.
module pin_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic cs_n_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_q,
    output logic cs_act
);
    logic [STAGES:0]   sck_pipe;
    logic [STAGES-1:0] sdi_pipe;
    logic [STAGES-1:0] cs_pipe;

    // Shift each pin through its synchronizer; select resets to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            sdi_pipe <= '0;
            cs_pipe  <= '1;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-1:0], sck_i};
            sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_i};
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_i};
        end
    end

    // Edges are taken from the last two pipe stages.
    always_comb begin
        sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
        sck_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
        sdi_q    = sdi_pipe[STAGES-1];
        cs_act   = ~cs_pipe[STAGES-1];
    end
endmodule

// File: rtl/frame_ctrl.sv
// Module: frame_ctrl
// Receives the instruction and data bits of a frame, keeps the current register
// address and issues write and read strobes to the register port. The address
// steps down once per byte. A read is fetched one byte ahead: once after the
// instruction and once after every byte. Assumes the sampler's edge pulses are
// at least four cycles apart.
module frame_ctrl
    import spi_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sdi_q,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rd_o,
    output logic              in_data_o
);
    phase_t              phase;
    logic [ICNT_W-1:0]   bitcnt;
    logic [INSTR_W-2:0]  sr;
    logic                is_rd;
    logic [ADDR_W-1:0]   addr;
    logic                wr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                rd_q;
    logic                step_q;

    localparam logic [ICNT_W-1:0] INSTR_LAST = ICNT_W'(INSTR_W - 1);
    localparam logic [ICNT_W-1:0] BYTE_LAST  = ICNT_W'(DATA_W - 1);

    // Frame sequencing: count bits, decode the instruction, commit bytes, step the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_INSTR;
            bitcnt  <= '0;
            sr      <= '0;
            is_rd   <= 1'b0;
            addr    <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rd_q    <= 1'b0;
            step_q  <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            step_q <= 1'b0;
            if (step_q) begin
                addr <= addr - 1'b1;
                rd_q <= is_rd && cs_act;
            end
            if (!cs_act) begin
                phase  <= PH_INSTR;
                bitcnt <= '0;
            end else if (sck_rise) begin
                sr <= {sr[INSTR_W-3:0], sdi_q};
                if (phase == PH_INSTR) begin
                    if (bitcnt == INSTR_LAST) begin
                        phase  <= PH_DATA;
                        bitcnt <= '0;
                        is_rd  <= sr[INSTR_W-2];
                        addr   <= {sr[INSTR_W-3:0], sdi_q};
                        rd_q   <= sr[INSTR_W-2];
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end else begin
                    if (bitcnt == BYTE_LAST) begin
                        bitcnt  <= '0;
                        step_q  <= 1'b1;
                        wr_q    <= ~is_rd;
                        wdata_q <= {sr[DATA_W-2:0], sdi_q};
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
            end
        end
    end

    // Drive the register port from the frame state.
    always_comb begin
        addr_o    = addr;
        wr_o      = wr_q;
        wdata_o   = wdata_q;
        rd_o      = rd_q;
        in_data_o = (phase == PH_DATA);
    end

    // R2
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |=> !wr_q);
    // R4 R5
    addr_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |=> addr == $past(addr) - 1'b1);
    // R6
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !wr_q);
    // R1
    no_rd_and_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_q && wr_q));
endmodule

// File: rtl/tx_shifter.sv
// Module: tx_shifter
// Holds the byte fetched for a read and shifts it out, most significant bit
// first, one bit per falling serial clock edge. Assumes the load strobe comes
// before the falling edge that starts the byte. Drives 0 outside read data.
module tx_shifter
    import spi_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              in_data,
    input  logic              sck_fall,
    input  logic              load,
    input  logic [DATA_W-1:0] rdata,
    input  logic              hit,
    output logic              sdo_o
);
    logic [DATA_W-1:0] tx;
    logic              sdo_q;

    // Load fetched bytes (zero when unmapped) and shift them out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx    <= '0;
            sdo_q <= 1'b0;
        end else if (!cs_act || !in_data) begin
            tx    <= '0;
            sdo_q <= 1'b0;
        end else if (load) begin
            tx <= hit ? rdata : '0;
        end else if (sck_fall) begin
            sdo_q <= tx[DATA_W-1];
            tx    <= {tx[DATA_W-2:0], 1'b0};
        end
    end

    assign sdo_o = sdo_q;

    // R7
    sdo_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act || !in_data) |=> !sdo_q);
    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !hit && cs_act && in_data) |=> tx == '0);
    // R3
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && in_data && !sck_fall) |=> $stable(sdo_q));
endmodule

// File: rtl/serial_reg_target.sv
// Module: serial_reg_target
// Top of the serial register target: pin sampling, frame control and the read
// shifter. Assumes the serial clock stays high and low for at least 8 system
// clocks each. The register port returns read data in the cycle of rf_rd_o.
module serial_reg_target
    import spi_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic              rf_wr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              rf_rd_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    input  logic              rf_hit_i
);
    logic sck_rise, sck_fall, sdi_q, cs_act, in_data, rd;

    pin_sampler #(.STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sdi_i(sdi_i), .cs_n_i(cs_n_i),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_q(sdi_q), .cs_act(cs_act)
    );

    frame_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise), .sdi_q(sdi_q),
        .addr_o(rf_addr_o), .wr_o(rf_wr_o), .wdata_o(rf_wdata_o), .rd_o(rd),
        .in_data_o(in_data)
    );

    tx_shifter u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .in_data(in_data), .sck_fall(sck_fall),
        .load(rd), .rdata(rf_rdata_i), .hit(rf_hit_i), .sdo_o(sdo_o)
    );

    assign rf_rd_o = rd;
endmodule

// File: tb/sim_serial_reg_target.sv
module sim_serial_reg_target;
    localparam int HALF = 8;
    localparam int MEMSZ = 1280;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [14:0] rf_addr;
    logic        rf_wr;
    logic [7:0]  rf_wdata;
    logic        rf_rd;
    logic [7:0]  rf_rdata;
    logic        rf_hit;

    int nvec = 0;
    int nbad = 0;

    logic [7:0]  mem [0:MEMSZ-1];
    logic [22:0] exp_wr [$];
    logic [7:0]  wbuf [$];

    always #10 clk = ~clk;

    function automatic bit mapped(input logic [14:0] a);
        return (a < 15'h0400) || (a >= 15'h7F00);
    endfunction

    function automatic int idx(input logic [14:0] a);
        return (a < 15'h0400) ? int'(a) : int'(a) - 32'h7F00 + 32'h400;
    endfunction

    assign rf_hit   = mapped(rf_addr);
    assign rf_rdata = rf_hit ? mem[idx(rf_addr)] : 8'hA5;

    serial_reg_target u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
        .rf_addr_o(rf_addr), .rf_wr_o(rf_wr), .rf_wdata_o(rf_wdata), .rf_rd_o(rf_rd),
        .rf_rdata_i(rf_rdata), .rf_hit_i(rf_hit)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Per-clock monitor of the write strobe against the expected write list.
    always @(negedge clk) begin
        if (rst_n && rf_wr) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R2/R6 unexpected write", {9'd0, rf_addr, rf_wdata}, 32'h0);
            end else begin
                logic [22:0] e;
                e = exp_wr.pop_front();
                check({rf_addr, rf_wdata} == e, "R2/R4 write", {9'd0, rf_addr, rf_wdata}, {9'd0, e});
                if (mapped(e[22:8])) mem[idx(e[22:8])] = e[7:0];
            end
        end
    end

    task automatic sel_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_high(input string tag);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF + 4) @(negedge clk);
        check(sdo == 1'b0, tag, {31'd0, sdo}, 32'd0);
    endtask

    task automatic clk_bit(input logic b, output logic got);
        @(negedge clk) sdi = b;
        repeat (HALF) @(negedge clk);
        got = sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_instr(input logic rd, input logic [14:0] a, input int nbits);
        logic [15:0] w;
        logic g;
        w = {rd, a};
        for (int i = 15; i > 15 - nbits; i--) begin
            clk_bit(w[i], g);
            check(g == 1'b0, "R7 instruction sdo", {31'd0, g}, 32'd0);
        end
    endtask

    task automatic wr_frame(input logic [14:0] a0);
        logic [14:0] a;
        logic g;
        a = a0;
        sel_low();
        send_instr(1'b0, a0, 16);
        foreach (wbuf[k]) begin
            exp_wr.push_back({a, wbuf[k]});
            for (int i = 7; i >= 0; i--) begin
                clk_bit(wbuf[k][i], g);
                check(g == 1'b0, "R7 write frame sdo", {31'd0, g}, 32'd0);
            end
            a = a - 15'd1;
        end
        sel_high("R7 sdo after write frame");
        check(exp_wr.size() == 0, "R2 writes pending", exp_wr.size(), 32'd0);
        wbuf.delete();
    endtask

    task automatic rd_frame(input logic [14:0] a0, input int n, input string tag);
        logic [14:0] a;
        logic [7:0] e, got;
        logic g;
        int clocks;
        a = a0;
        sel_low();
        send_instr(1'b1, a0, 16);
        clocks = 16;
        for (int k = 0; k < n; k++) begin
            e = mapped(a) ? mem[idx(a)] : 8'h00;
            for (int i = 7; i >= 0; i--) begin
                clk_bit(1'b0, g);
                got[i] = g;
                clocks++;
            end
            check(got == e, tag, {17'd0, a, got}, {17'd0, a, e});
            a = a - 15'd1;
        end
        if (n == 4) check(clocks == 48, "R10 clock count", clocks, 32'd48);
        sel_high("R7 sdo after read frame");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 7 + 3) & 8'hFF);
        repeat (5) @(negedge clk);
        check({sdo, rf_wr, rf_rd} == 3'b000, "R9 in reset", {29'd0, sdo, rf_wr, rf_rd}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({sdo, rf_wr, rf_rd} == 3'b000, "R9 after reset", {29'd0, sdo, rf_wr, rf_rd}, 32'd0);

        // R1 R3: single byte read of a preset location
        rd_frame(15'h0050, 1, "R1/R3 single read");
        // R2 R4: streaming write downward, then R10 four-byte read back
        wbuf = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr_frame(15'h0203);
        rd_frame(15'h0203, 4, "R10/R4 stream read");
        // R5: write across the bottom of the address space, read back across it
        wbuf = '{8'h5A, 8'hC3, 8'h7E};
        wr_frame(15'h0001);
        rd_frame(15'h0000, 2, "R5 wrap read");
        rd_frame(15'h7FFF, 1, "R5 top address");
        // R8: unmapped address, then stream into mapped space
        rd_frame(15'h1234, 1, "R8 unmapped read");
        rd_frame(15'h0400, 2, "R8/R4 unmapped to mapped");
        // R6: abort inside a write data byte
        sel_low();
        send_instr(1'b0, 15'h0100, 16);
        for (int i = 0; i < 5; i++) begin
            logic g;
            clk_bit(1'b1, g);
        end
        sel_high("R6/R7 sdo after abort");
        // R6: abort inside an instruction
        sel_low();
        send_instr(1'b1, 15'h0000, 7);
        sel_high("R6/R7 sdo after short frame");
        rd_frame(15'h0100, 1, "R6 byte untouched after abort");
        // R2: single write, mixed bit pattern, read back
        wbuf = '{8'h96};
        wr_frame(15'h0100);
        rd_frame(15'h0100, 1, "R2 single write read back");

        check(exp_wr.size() == 0, "R6 no stray writes", exp_wr.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule